// File: doc/BRIEF.md
# Indexed Register Port for a Real-Time Clock

This block is the host side of a real-time clock. It exposes a 128-byte register and storage space through two addresses. A host access to the even address loads an index pointer. An access to the odd address reads or writes the byte that the pointer selects.

Most bytes behave as plain storage. The four control bytes at indices 10 to 13 have side effects:

- Control byte A has a status bit in bit 7 that the host cannot write. This bit is set and cleared by the time-keeping logic.
- Writing control byte B with its freeze bit (bit 7) high clears the status bit in A.
- Control byte C collects event flags, drives the interrupt line, and empties when it is read.
- Control byte D is read-only.

The port also tells the calendar block to reload its running time from the register bytes. It does this after a host write to a time or date byte while the freeze bit is low, and when the host releases the freeze bit.

The host interface is strobe-based. An access takes effect on the rising edge of `acc_sel_i`, so holding the select high performs only one access. Read data appears on `acc_rdata_o` one clock after the access edge and holds until the next read. The byte store has no reset and one write port, so it maps onto block RAM.

Top module: `rtc_index_port`

## Requirements
- R1: After reset, control bytes A, B, C and D read back as 0x26, 0x02, 0x00 and 0x80. The index is 0, `irq_o` is low and `reload_o` is low.
- R2: A write to address 0 stores `acc_wdata_i[6:0]` as the index. A read from address 0 returns 0x00 on `acc_rdata_o`.
- R3: A write to address 1 stores the data at the indexed byte. A read from address 1 puts the indexed byte on `acc_rdata_o` one clock after the access edge, and the value holds until the next read. Indices 0 to 9 and 14 to 127 behave as plain storage.
- R4: A write to control byte A (index 10) replaces bits 6 to 0 and keeps bit 7. Bit 7 of A is set by a `uip_set_i` pulse only while bit 7 of B is low. It is cleared by a `uip_clr_i` pulse, and the clear wins over the set.
- R5: Writing control byte B (index 11) with bit 7 high clears bit 7 of A.
- R6: Host writes to control byte C (index 12) and control byte D (index 13) change nothing.
- R7: A read of C returns its current value and then clears C to 0x00, so `irq_o` falls on the next clock. An event that arrives in the same clock as the clearing read is kept.
- R8: Event input bits 2, 1 and 0 (periodic, alarm, update-ended) set bits 6, 5 and 4 of C respectively. Any event also sets bit 7 of C, and `irq_o` equals bit 7 of C.
- R9: A write to a time or date byte (index 0, 2, 4, 6, 7, 8 or 9) while bit 7 of B is low raises `reload_o` for one clock after the access. The same write while bit 7 of B is high does not.
- R10: Writing B with bit 7 low while bit 7 of B was high raises `reload_o` for one clock.
- R11: An access takes effect only on the clock in which `acc_sel_i` rises. A select held high for several clocks performs exactly one access, so one long read of C clears it only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_sel_i | input | 1 | Access select; an access is taken on its rising edge |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 1 | 0 = index pointer, 1 = indexed byte |
| acc_wdata_i | input | DATA_W | Write data |
| acc_rdata_o | output | DATA_W | Read data, registered |
| uip_set_i | input | 1 | Pulse from time keeping: raise the update status bit |
| uip_clr_i | input | 1 | Pulse from time keeping: drop the update status bit |
| evt_i | input | 3 | Event pulses {periodic, alarm, update-ended} |
| irq_o | output | 1 | Interrupt line, equal to bit 7 of C |
| reload_o | output | 1 | One-clock request to reload the calendar from the register bytes |

## Verification
The bench holds the select high across a read of C while a new event arrives. A design that acts on the select level would clear that event before the host sees it. It also raises and drops the update status bit against writes of A and of B with the freeze bit set. A design that let the host write bit 7 of A, or that ignored the freeze write, would report a stale update-in-progress. Reload requests are checked for time bytes, alarm bytes, writes while frozen and release of the freeze bit. A wrong time-byte decode or a missing edge check on B shows up as an extra or missing pulse, and the per-clock model comparison reports it.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
  localparam int IX_A = 10;
  localparam int IX_B = 11;
  localparam int IX_C = 12;
  localparam int IX_D = 13;
  localparam logic [7:0] A_RST = 8'h26;
  localparam logic [7:0] B_RST = 8'h02;
  localparam logic [7:0] D_VAL = 8'h80;
  localparam int EVT_W = 3;

  function automatic logic is_clock_byte(input int ix);
    return (ix == 0) || (ix == 2) || (ix == 4) || (ix == 6) ||
           (ix == 7) || (ix == 8) || (ix == 9);
  endfunction

  function automatic logic is_ctrl_byte(input int ix);
    return (ix >= IX_A) && (ix <= IX_D);
  endfunction
endpackage

// File: rtl/rtcp_front.sv
module rtcp_front #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              idx_wr_o,
  output logic              ptr_rd_o,
  output logic              data_wr_o,
  output logic              data_rd_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic sel_q;
  logic acc;

  assign acc       = sel_i & ~sel_q;
  assign idx_wr_o  = acc & ~addr_i & wr_i;
  assign ptr_rd_o  = acc & ~addr_i & ~wr_i;
  assign data_wr_o = acc & addr_i & wr_i;
  assign data_rd_o = acc & addr_i & ~wr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      idx_o <= '0;
    end else begin
      sel_q <= sel_i;
      if (idx_wr_o) idx_o <= wdata_i[IDX_W-1:0];
    end
  end

  AST_ONE_ACCESS_PER_STROBE: assert property (@(posedge clk) disable iff (rst)
    acc |=> !acc); // R11

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
    idx_wr_o |=> idx_o == $past(wdata_i[IDX_W-1:0])); // R2
endmodule

// File: rtl/rtcp_store.sv
module rtcp_store #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/rtcp_ctrl.sv
module rtcp_ctrl
  import rtcp_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              uip_set_i,
  input  logic              uip_clr_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [DATA_W-1:0] ctrl_val_o,
  output logic              irq_o,
  output logic              reload_o
);
  localparam int TOP = DATA_W - 1;

  logic [DATA_W-1:0] a_q, b_q, c_q;
  logic wr_a, wr_b, wr_c, wr_d, rd_c, wr_clock;
  logic a_top_nx;
  logic [DATA_W-1:0] c_evt;

  assign wr_a     = data_wr_i && (int'(idx_i) == IX_A);
  assign wr_b     = data_wr_i && (int'(idx_i) == IX_B);
  assign wr_c     = data_wr_i && (int'(idx_i) == IX_C);
  assign wr_d     = data_wr_i && (int'(idx_i) == IX_D);
  assign rd_c     = data_rd_i && (int'(idx_i) == IX_C);
  assign wr_clock = data_wr_i && is_clock_byte(int'(idx_i));

  always_comb begin
    c_evt = '0;
    c_evt[TOP] = |evt_i;
    c_evt[TOP-1 -: EVT_W] = evt_i;
  end

  assign a_top_nx = (a_q[TOP] | (uip_set_i & ~b_q[TOP])) & ~uip_clr_i &
                    ~(wr_b & wdata_i[TOP]);

  always_comb begin
    case (int'(idx_i))
      IX_A:    ctrl_val_o = a_q;
      IX_B:    ctrl_val_o = b_q;
      IX_C:    ctrl_val_o = c_q;
      default: ctrl_val_o = D_VAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= A_RST;
      b_q      <= B_RST;
      c_q      <= '0;
      reload_o <= 1'b0;
    end else begin
      a_q[TOP] <= a_top_nx;
      if (wr_a) a_q[TOP-1:0] <= wdata_i[TOP-1:0];
      if (wr_b) b_q <= wdata_i;
      c_q      <= (rd_c ? '0 : c_q) | c_evt;
      reload_o <= (wr_clock & ~b_q[TOP]) |
                  (wr_b & b_q[TOP] & ~wdata_i[TOP]);
    end
  end

  assign irq_o = c_q[TOP];

  AST_A_LOW_FROM_HOST: assert property (@(posedge clk) disable iff (rst)
    wr_a |=> a_q[TOP-1:0] == $past(wdata_i[TOP-1:0])); // R4

  AST_B_SET_DROPS_UIP: assert property (@(posedge clk) disable iff (rst)
    (wr_b && wdata_i[TOP]) |=> !a_q[TOP]); // R5

  AST_C_IGNORES_WRITE: assert property (@(posedge clk) disable iff (rst)
    ((wr_c || wr_d) && evt_i == '0) |=> $stable(c_q)); // R6

  AST_C_ZERO_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_c && evt_i == '0) |=> c_q == '0); // R7

  AST_RELOAD_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (wr_b && b_q[TOP] && !wdata_i[TOP]) |=> reload_o); // R10
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtcp_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_sel_i,
  input  logic              acc_wr_i,
  input  logic              acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  input  logic              uip_set_i,
  input  logic              uip_clr_i,
  input  logic [2:0]        evt_i,
  output logic              irq_o,
  output logic              reload_o
);
  logic             idx_wr, ptr_rd, data_wr, data_rd;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] ctrl_val, mem_rd;
  logic             hit_ctrl, use_reg_q;
  logic [DATA_W-1:0] reg_rd_q;

  rtcp_front #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_front (
    .clk(clk), .rst(rst), .sel_i(acc_sel_i), .wr_i(acc_wr_i),
    .addr_i(acc_addr_i), .wdata_i(acc_wdata_i), .idx_wr_o(idx_wr),
    .ptr_rd_o(ptr_rd), .data_wr_o(data_wr), .data_rd_o(data_rd),
    .idx_o(idx)
  );

  assign hit_ctrl = is_ctrl_byte(int'(idx));

  rtcp_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .data_wr_i(data_wr), .data_rd_i(data_rd),
    .idx_i(idx), .wdata_i(acc_wdata_i), .uip_set_i(uip_set_i),
    .uip_clr_i(uip_clr_i), .evt_i(evt_i), .ctrl_val_o(ctrl_val),
    .irq_o(irq_o), .reload_o(reload_o)
  );

  rtcp_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we_i(data_wr & ~hit_ctrl), .waddr_i(idx),
    .wdata_i(acc_wdata_i), .re_i(data_rd & ~hit_ctrl), .raddr_i(idx),
    .rdata_o(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      use_reg_q <= 1'b1;
      reg_rd_q  <= '0;
    end else if (ptr_rd) begin
      use_reg_q <= 1'b1;
      reg_rd_q  <= '0;
    end else if (data_rd) begin
      use_reg_q <= hit_ctrl;
      reg_rd_q  <= ctrl_val;
    end
  end

  assign acc_rdata_o = use_reg_q ? reg_rd_q : mem_rd;

  AST_POINTER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ptr_rd |=> acc_rdata_o == '0); // R2
endmodule

// File: tb/rtc_index_port_tb.sv
`timescale 1ns/1ps
module rtc_index_port_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic uset = 1'b0, uclr = 1'b0;
  logic [2:0] evt = '0;
  logic irq, reload;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_index_port dut_i (
    .clk(clk), .rst(rst), .acc_sel_i(sel), .acc_wr_i(wr), .acc_addr_i(addr),
    .acc_wdata_i(wdata), .acc_rdata_o(rdata), .uip_set_i(uset),
    .uip_clr_i(uclr), .evt_i(evt), .irq_o(irq), .reload_o(reload)
  );

  // Behavioural reference model
  int m_mem [128];
  int m_a, m_b, m_c, m_idx, m_rd;
  bit m_prev, m_reload;

  always @(posedge clk) begin
    int old_b;
    bit acc, clear_c;
    if (rst) begin
      m_a = 'h26; m_b = 'h02; m_c = 0; m_idx = 0; m_rd = 0;
      m_prev = 0; m_reload = 0;
    end else begin
      acc = sel && !m_prev;
      old_b = m_b;
      clear_c = 0;
      m_reload = 0;
      if (acc && !addr) begin
        if (wr) m_idx = wdata & 127; else m_rd = 0;
      end else if (acc && wr) begin
        if (m_idx == 10) m_a = (m_a & 128) | (wdata & 127);
        else if (m_idx == 11) begin
          if ((old_b & 128) && !(wdata & 128)) m_reload = 1;
          m_b = wdata;
        end else if (m_idx != 12 && m_idx != 13) begin
          m_mem[m_idx] = wdata;
          if ((m_idx inside {0, 2, 4, 6, 7, 8, 9}) && !(old_b & 128)) m_reload = 1;
        end
      end else if (acc) begin
        case (m_idx)
          10: m_rd = m_a;
          11: m_rd = old_b;
          12: begin m_rd = m_c; clear_c = 1; end
          13: m_rd = 'h80;
          default: m_rd = m_mem[m_idx];
        endcase
      end
      if (uset && !(old_b & 128)) m_a = m_a | 128;
      if (uclr) m_a = m_a & 127;
      if (acc && addr && wr && m_idx == 11 && (wdata & 128)) m_a = m_a & 127;
      if (clear_c) m_c = 0;
      if (evt != 0) m_c = m_c | 128 | (evt << 4);
      m_prev = sel;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(rdata) == m_rd, "R3 model rdata", rdata, m_rd);
      check(irq == m_c[7], "R8 model irq", irq, m_c[7]);
      check(reload == m_reload, "R9 model reload", reload, m_reload);
    end
  end

  // one access: select for one clock, sample after the access edge
  task automatic access(input bit a, input bit w, input int d, output int rd, output bit rl);
    @(negedge clk);
    sel = 1; addr = a; wr = w; wdata = d[7:0];
    @(negedge clk);
    sel = 0;
    #0.5;
    rd = rdata; rl = reload;
  endtask

  task automatic wr_byte(input int ix, input int d, output bit rl);
    int rd; bit r0;
    access(0, 1, ix, rd, r0);
    access(1, 1, d, rd, rl);
  endtask

  task automatic rd_byte(input int ix, output int v);
    bit r0;
    access(0, 1, ix, v, r0);
    access(1, 0, 0, v, r0);
  endtask

  task automatic pulse(input bit s, input bit c, input logic [2:0] e);
    @(negedge clk);
    uset = s; uclr = c; evt = e;
    @(negedge clk);
    uset = 0; uclr = 0; evt = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=0x00 expected=0x01");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v; bit rl;
    repeat (3) @(negedge clk);
    rst = 0;
    #0.5;
    check(irq == 0 && reload == 0 && rdata == 0, "R1 reset outputs", {irq, reload}, 0);
    rd_byte(10, v); check(v == 'h26, "R1 reset A", v, 'h26);
    rd_byte(11, v); check(v == 'h02, "R1 reset B", v, 'h02);
    rd_byte(12, v); check(v == 'h00, "R1 reset C", v, 'h00);
    rd_byte(13, v); check(v == 'h80, "R1 reset D", v, 'h80);

    // R2: index uses low 7 bits; pointer read gives zero
    wr_byte(14, 'h5A, rl);
    wr_byte('h80 | 14, 'hC3, rl);
    rd_byte(14, v); check(v == 'hC3, "R2 index masks bit 7", v, 'hC3);
    access(0, 0, 0, v, rl); check(v == 0, "R2 pointer read", v, 0);

    // R3: plain storage
    wr_byte(127, 'hA5, rl); check(rl == 0, "R3 no reload for storage", rl, 0);
    wr_byte(1, 'h3C, rl); check(rl == 0, "R3 alarm byte no reload", rl, 0);
    rd_byte(127, v); check(v == 'hA5, "R3 byte 127", v, 'hA5);
    rd_byte(1, v); check(v == 'h3C, "R3 byte 1", v, 'h3C);
    repeat (3) @(negedge clk);
    check(rdata == 'h3C, "R3 read data holds", rdata, 'h3C);

    // R9: time byte write reloads while not frozen
    wr_byte(0, 'h45, rl); check(rl == 1, "R9 reload on seconds write", rl, 1);
    wr_byte(9, 'h24, rl); check(rl == 1, "R9 reload on year write", rl, 1);

    // R4: status bit is not host writable
    pulse(1, 0, 0);
    wr_byte(10, 'h05, rl);
    rd_byte(10, v); check(v == 'h85, "R4 A keeps bit 7", v, 'h85);
    pulse(1, 1, 0);
    rd_byte(10, v); check(v == 'h05, "R4 clear wins over set", v, 'h05);
    pulse(1, 0, 0);

    // R5: freeze write drops status bit
    wr_byte(11, 'h82, rl);
    rd_byte(10, v); check(v == 'h05, "R5 freeze clears status", v, 'h05);
    pulse(1, 0, 0);
    rd_byte(10, v); check(v == 'h05, "R4 no set while frozen", v, 'h05);
    wr_byte(2, 'h30, rl); check(rl == 0, "R9 no reload while frozen", rl, 0);
    rd_byte(2, v); check(v == 'h30, "R3 time byte stored", v, 'h30);
    wr_byte(11, 'h82, rl); check(rl == 0, "R10 no reload staying frozen", rl, 0);
    wr_byte(11, 'h02, rl); check(rl == 1, "R10 reload on release", rl, 1);

    // R6: writes to C and D ignored
    wr_byte(12, 'hFF, rl);
    wr_byte(13, 'h00, rl);
    check(irq == 0, "R6 C write no irq", irq, 0);
    rd_byte(12, v); check(v == 'h00, "R6 C unchanged", v, 'h00);
    rd_byte(13, v); check(v == 'h80, "R6 D unchanged", v, 'h80);

    // R8 / R7: events and clear-on-read
    pulse(0, 0, 3'b100);
    #0.5 check(irq == 1, "R8 irq raised", irq, 1);
    pulse(0, 0, 3'b001);
    rd_byte(12, v); check(v == 'hD0, "R8 C flags", v, 'hD0);
    check(irq == 0, "R7 irq drops after read", irq, 0);
    rd_byte(12, v); check(v == 'h00, "R7 C cleared", v, 'h00);

    // R7: event coinciding with clearing read is kept
    pulse(0, 0, 3'b010);
    access(0, 1, 12, v, rl);
    @(negedge clk);
    sel = 1; addr = 1; wr = 0; evt = 3'b001;
    @(negedge clk);
    sel = 0; evt = 0;
    #0.5 check(rdata == 'hA0, "R7 read value", rdata, 'hA0);
    check(irq == 1, "R7 same-cycle event kept", irq, 1);
    rd_byte(12, v); check(v == 'h90, "R7 kept flags", v, 'h90);

    // R11: a held select performs one access only
    access(0, 1, 12, v, rl);
    @(negedge clk);
    sel = 1; addr = 1; wr = 0;
    @(negedge clk);
    evt = 3'b001;
    @(negedge clk);
    evt = 0;
    repeat (2) @(negedge clk);
    sel = 0;
    #0.5 check(irq == 1, "R11 held select no second clear", irq, 1);
    rd_byte(12, v); check(v == 'h90, "R11 event survives held read", v, 'h90);
    @(negedge clk);
    sel = 1; addr = 1; wr = 1; wdata = 'h77;
    access(0, 1, 20, v, rl);
    wr_byte(20, 'h11, rl);
    @(negedge clk);
    sel = 1; addr = 1; wr = 1; wdata = 'h22;
    repeat (3) @(negedge clk);
    wdata = 'h33;
    @(negedge clk);
    sel = 0;
    rd_byte(20, v); check(v == 'h22, "R11 held write taken once", v, 'h22);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule